// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Dual-Channel Converter

This block is the serial-bus slave side of a small two-channel converter. It watches an already synchronised and oversampled clock line and data line. It finds start, repeated start and stop conditions and matches a fixed seven-bit device address. It acknowledges by asserting an open-drain pull-down enable on the data line. Bytes written after a write address are steered into one of two control registers by their top bit. After a read address, the block fetches 12-bit conversion results from a result-memory port and shifts each one out as two bytes.

The block also recognises the high-speed master code. It answers that code with a not-acknowledge and raises a speed-mode flag. The flag stays set across repeated starts and is cleared by a stop. The register fields come out as plain outputs for the analog and conversion logic that sits next to the block.

Top module: `adc_serial_ctl`

## Requirements
- R1: After reset, ref_sel is 000, ext_clk is 0, bipolar is 0, scan_mode is 00, chan_sel is 0, single_ended is 1, hs_mode is 0 and sda_oe is 0 (line released).
- R2: An address byte whose upper seven bits equal 0110110 is acknowledged: sda_oe is high during the ninth clock pulse. Any other address, other than a master code, is not acknowledged, and the bytes that follow it are not acknowledged either.
- R3: A written byte with bit 7 = 1 loads the setup fields: bits 6:4 go to ref_sel, bit 3 to ext_clk and bit 2 to bipolar. Bit 0 is ignored. The configuration fields change only as R5 states.
- R4: A written byte with bit 7 = 0 loads the configuration fields: bits 6:5 go to scan_mode, bit 1 to chan_sel and bit 0 to single_ended. Bits 4:2 are ignored. The setup fields stay unchanged. Every byte written after a matched write address is acknowledged, whatever the order or the number of bytes.
- R5: A setup byte with bit 1 = 0 returns the configuration fields to their reset values (scan_mode 00, chan_sel 0, single_ended 1), while the setup fields still take the new byte.
- R6: An address-phase byte of the form 00001xxx is not acknowledged, and hs_mode is high once that ninth pulse ends. A repeated start keeps hs_mode. A stop clears it.
- R7: After a matched read address (bit 0 = 1), read_request pulses for one cycle and the block acknowledges. It then sends the result on rd_data as two bytes, MSB first: four 1 bits followed by bits 11:8, then bits 7:0.
- R8: When the master acknowledges the second byte of a result, next_result pulses once and the next two bytes carry the new rd_data. When the master does not acknowledge a read byte, sda_oe stays low until the next start.
- R9: A start or stop that arrives partway through a byte abandons that byte, and no register changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised serial clock level |
| sda_in | input | 1 | Synchronised serial data level, as seen on the wired bus |
| sda_oe | output | 1 | High pulls the data line low (open drain) |
| rd_data | input | RES_W | Current result from the result memory |
| read_request | output | 1 | One-cycle strobe after a read address is accepted |
| next_result | output | 1 | One-cycle strobe asking for the next result |
| hs_mode | output | 1 | High-speed bus mode flag |
| ref_sel | output | 3 | Reference selection field |
| ext_clk | output | 1 | Conversion clock source select |
| bipolar | output | 1 | Bipolar coding select |
| scan_mode | output | 2 | Scan configuration field |
| chan_sel | output | 1 | Channel select |
| single_ended | output | 1 | Single-ended (1) or differential (0) input |

## Verification
The bench sends every possible address byte. A decoder that compares too few bits would acknowledge a neighbouring address, and a loose master-code test would raise hs_mode on ordinary addresses. It sweeps every setup pattern after a non-default configuration write, so a design that ignores the restore bit, or that also clears the setup fields, shows wrong field values. Multi-result reads check the four leading 1 bits, the byte order and the result advance, which catch a missing pad, swapped bytes or an advance on the wrong acknowledge. Aborted bytes and a repeated start in high-speed mode expose a design that commits partial bytes or drops the speed flag too early.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } xfer_state_t;

  typedef struct packed {
    logic [2:0] ref_sel;
    logic       ext_clk;
    logic       bipolar;
  } setup_t;

  typedef struct packed {
    logic [1:0] scan;
    logic       chan_sel;
    logic       single_ended;
  } config_t;

  localparam setup_t  SETUP_DEFAULT = '{ref_sel: 3'b000, ext_clk: 1'b0, bipolar: 1'b0};
  localparam config_t CFG_DEFAULT   = '{scan: 2'b00, chan_sel: 1'b0, single_ended: 1'b1};
endpackage

// File: rtl/bus_line_events.sv
module bus_line_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      start_evt <= 1'b0;
      stop_evt  <= 1'b0;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      sda_s     <= 1'b1;
    end else begin
      scl_q     <= scl_in;
      sda_q     <= sda_in;
      start_evt <= scl_q & scl_in & sda_q & ~sda_in;
      stop_evt  <= scl_q & scl_in & ~sda_q & sda_in;
      scl_rise  <= ~scl_q & scl_in;
      scl_fall  <= scl_q & ~scl_in;
      sda_s     <= sda_in;
    end
  end

  assert_edges_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(scl_rise && scl_fall) && !(start_evt && scl_fall));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import adcif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output setup_t            setup_q,
  output config_t           cfg_q
);
  logic unused_dc_bits;
  assign unused_dc_bits = ^wr_data[4:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q <= SETUP_DEFAULT;
      cfg_q   <= CFG_DEFAULT;
    end else if (wr_en) begin
      if (wr_data[7]) begin
        setup_q.ref_sel <= wr_data[6:4];
        setup_q.ext_clk <= wr_data[3];
        setup_q.bipolar <= wr_data[2];
        if (!wr_data[1]) cfg_q <= CFG_DEFAULT;
      end else begin
        cfg_q.scan         <= wr_data[6:5];
        cfg_q.chan_sel     <= wr_data[1];
        cfg_q.single_ended <= wr_data[0];
      end
    end
  end

  assert_setup_kept_on_cfg_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[7]) |=> (setup_q == $past(setup_q)));
  assert_cfg_restore_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[7] && !wr_data[1]) |=> (cfg_q == CFG_DEFAULT));
  assert_regs_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cfg_q) && $stable(setup_q)));
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import adcif_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0110110,
  parameter int         RES_W    = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [RES_W-1:0]  rd_data,
  output logic              sda_oe,
  output logic              hs_mode,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              read_request,
  output logic              next_result
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [4:0] MCODE = 5'b00001;

  xfer_state_t       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txreg, lo_byte;
  logic              rw_q, mc_q, second, master_ack;
  logic [WORD_W-1:0] padded;

  // Result widened to two bytes with leading ones
  always_comb begin
    padded = '1;
    padded[RES_W-1:0] = rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      txreg        <= '0;
      lo_byte      <= '0;
      rw_q         <= 1'b0;
      mc_q         <= 1'b0;
      second       <= 1'b0;
      master_ack   <= 1'b0;
      sda_oe       <= 1'b0;
      hs_mode      <= 1'b0;
      wr_en        <= 1'b0;
      wr_data      <= '0;
      read_request <= 1'b0;
      next_result  <= 1'b0;
    end else begin
      wr_en        <= 1'b0;
      read_request <= 1'b0;
      next_result  <= 1'b0;
      if (stop_evt) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        hs_mode <= 1'b0;
      end else if (start_evt) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_WR) begin
                wr_en   <= 1'b1;
                wr_data <= shreg;
                sda_oe  <= 1'b1;
                state   <= ST_WR_ACK;
              end else if (shreg[7:1] == DEV_ADDR) begin
                sda_oe       <= 1'b1;
                rw_q         <= shreg[0];
                read_request <= shreg[0];
                mc_q         <= 1'b0;
                state        <= ST_ADDR_ACK;
              end else if (shreg[7:3] == MCODE) begin
                mc_q  <= 1'b1;
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (mc_q) begin
                hs_mode <= 1'b1;
                sda_oe  <= 1'b0;
                state   <= ST_IDLE;
              end else if (rw_q) begin
                sda_oe  <= ~padded[WORD_W-1];
                txreg   <= {padded[WORD_W-2:BYTE_W], 1'b0};
                lo_byte <= padded[BYTE_W-1:0];
                second  <= 1'b0;
                cnt     <= CNT_W'(1);
                state   <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                sda_oe <= ~txreg[BYTE_W-1];
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              master_ack  <= ~sda_s;
              next_result <= ~sda_s & second;
            end else if (scl_fall) begin
              if (master_ack) begin
                cnt <= CNT_W'(1);
                if (!second) begin
                  sda_oe <= ~lo_byte[BYTE_W-1];
                  txreg  <= {lo_byte[BYTE_W-2:0], 1'b0};
                  second <= 1'b1;
                end else begin
                  sda_oe  <= ~padded[WORD_W-1];
                  txreg   <= {padded[WORD_W-2:BYTE_W], 1'b0};
                  lo_byte <= padded[BYTE_W-1:0];
                  second  <= 1'b0;
                end
                state <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_pull_on_scl_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  assert_start_releases_R9: assert property (@(posedge clk) disable iff (rst)
    (start_evt || stop_evt) |=> !sda_oe);
  assert_stop_clears_hs_R6: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !hs_mode);
  assert_hs_after_nack_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> ($past(scl_fall) && !$past(sda_oe)));
  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({read_request, next_result, wr_en}));
  assert_next_single_R8: assert property (@(posedge clk) disable iff (rst)
    next_result |=> !next_result);
endmodule

// File: rtl/adc_serial_ctl.sv
module adc_serial_ctl
  import adcif_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0110110,
  parameter int         RES_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  input  logic [RES_W-1:0] rd_data,
  output logic             read_request,
  output logic             next_result,
  output logic             hs_mode,
  output logic [2:0]       ref_sel,
  output logic             ext_clk,
  output logic             bipolar,
  output logic [1:0]       scan_mode,
  output logic             chan_sel,
  output logic             single_ended
);
  logic              start_evt, stop_evt, scl_rise, scl_fall, sda_s;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data;
  setup_t            setup_q;
  config_t           cfg_q;

  bus_line_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s)
  );

  xfer_engine #(.DEV_ADDR(DEV_ADDR), .RES_W(RES_W)) u_engine (
    .clk          (clk),
    .rst          (rst),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_s        (sda_s),
    .rd_data      (rd_data),
    .sda_oe       (sda_oe),
    .hs_mode      (hs_mode),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .read_request (read_request),
    .next_result  (next_result)
  );

  cfg_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .setup_q (setup_q),
    .cfg_q   (cfg_q)
  );

  assign ref_sel      = setup_q.ref_sel;
  assign ext_clk      = setup_q.ext_clk;
  assign bipolar      = setup_q.bipolar;
  assign scan_mode    = cfg_q.scan;
  assign chan_sel     = cfg_q.chan_sel;
  assign single_ended = cfg_q.single_ended;
endmodule

// File: tb/tb_adc_serial_ctl.sv
module tb_adc_serial_ctl;
  localparam int HALF = 4;
  localparam logic [6:0] ADDR = 7'b0110110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, read_request, next_result, hs_mode;
  logic ext_clk, bipolar, chan_sel, single_ended;
  logic [2:0] ref_sel;
  logic [1:0] scan_mode;
  logic [11:0] rd_data;
  logic [7:0] idx = '0;
  logic sda_line;

  int checks = 0;
  int errors = 0;

  logic [2:0] e_sel;
  logic e_ext, e_bip, e_cs, e_sgl;
  logic [1:0] e_scan;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  function automatic logic [11:0] result_of(input logic [7:0] i);
    return 12'hA5C + 12'(i) * 12'h3B7;
  endfunction
  assign rd_data = result_of(idx);

  always @(posedge clk) begin
    if (read_request) idx <= '0;
    else if (next_result) idx <= idx + 1'b1;
  end

  adc_serial_ctl dut (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .rd_data(rd_data), .read_request(read_request), .next_result(next_result),
    .hs_mode(hs_mode), .ref_sel(ref_sel), .ext_clk(ext_clk), .bipolar(bipolar),
    .scan_mode(scan_mode), .chan_sel(chan_sel), .single_ended(single_ended)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half_t();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; half_t();
    m_scl = 1'b1; half_t();
    m_sda = 1'b0; half_t();
    m_scl = 1'b0; half_t();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; half_t();
    m_scl = 1'b1; half_t();
    m_sda = 1'b1; half_t();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; half_t();
    m_scl = 1'b1; half_t();
    m_scl = 1'b0; half_t();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; half_t();
    m_scl = 1'b1;
    repeat (HALF / 2) @(negedge clk);
    ack = ~sda_line;
    repeat (HALF - HALF / 2) @(negedge clk);
    m_scl = 1'b0; half_t();
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; half_t();
      m_scl = 1'b1;
      repeat (HALF / 2) @(negedge clk);
      b[i] = sda_line;
      repeat (HALF - HALF / 2) @(negedge clk);
      m_scl = 1'b0; half_t();
    end
    send_bit(~mack);
    m_sda = 1'b1;
  endtask

  task automatic model_write(input logic [7:0] b);
    if (b[7]) begin
      e_sel = b[6:4]; e_ext = b[3]; e_bip = b[2];
      if (!b[1]) begin e_scan = 2'b00; e_cs = 1'b0; e_sgl = 1'b1; end
    end else begin
      e_scan = b[6:5]; e_cs = b[1]; e_sgl = b[0];
    end
  endtask

  task automatic check_regs(input string req);
    logic [7:0] act, exp;
    act = {ref_sel, ext_clk, bipolar, scan_mode, chan_sel, single_ended} >> 1;
    act = {ref_sel, ext_clk, bipolar, 3'b000};
    exp = {e_sel, e_ext, e_bip, 3'b000};
    chk(act == exp, req, act, exp);
    act = {4'b0, scan_mode, chan_sel, single_ended};
    exp = {4'b0, e_scan, e_cs, e_sgl};
    chk(act == exp, req, act, exp);
  endtask

  task automatic write_txn(input logic [7:0] b0, input logic [7:0] b1, input bit two, input string req);
    logic a;
    bus_start();
    write_byte({ADDR, 1'b0}, a);
    chk(a == 1'b1, "R2", a, 1);
    write_byte(b0, a);
    chk(a == 1'b1, req, a, 1);
    model_write(b0);
    if (two) begin
      write_byte(b1, a);
      chk(a == 1'b1, req, a, 1);
      model_write(b1);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] rb, expb;
    logic [11:0] rv;
    e_sel = 3'b000; e_ext = 1'b0; e_bip = 1'b0;
    e_scan = 2'b00; e_cs = 1'b0; e_sgl = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset values
    check_regs("R1");
    chk(hs_mode == 1'b0, "R1", hs_mode, 0);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);

    // R2 and R6: every address byte
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      bit match, mcode;
      b = 8'(v);
      match = (b[7:1] == ADDR);
      mcode = (b[7:3] == 5'b00001);
      bus_start();
      write_byte(b, a);
      chk(a == match, "R2", a, match);
      if (mcode) chk(hs_mode == 1'b1, "R6", hs_mode, 1);
      else       chk(hs_mode == 1'b0, "R6", hs_mode, 0);
      if (match && b[0]) begin
        read_byte(rb, 1'b0);
      end else if (!match && !mcode && !b[0]) begin
        write_byte(8'hE5, a);
        chk(a == 1'b0, "R2 ignored after mismatch", a, 0);
      end
      bus_stop();
      chk(hs_mode == 1'b0, "R6 stop", hs_mode, 0);
    end
    check_regs("R2 no change");

    // R3 and R5: all setup patterns after a non-default configuration
    for (int v = 0; v < 64; v++) begin
      write_txn(8'h62, {1'b1, 6'(v), 1'b1 ^ v[0]}, 1'b1, "R3");
      check_regs(v[0] ? "R3" : "R5");
    end

    // R4: configuration patterns, don't-care bits varied
    for (int k = 0; k < 16; k++) begin
      write_txn(8'hF6, {1'b0, 2'(k >> 2), 3'(k * 5), 2'(k)}, 1'b1, "R4");
      check_regs("R4");
    end
    write_txn(8'h41, 8'h00, 1'b0, "R4");
    check_regs("R4 single byte");

    // R7 and R8: three results, then master NACK
    bus_start();
    write_byte({ADDR, 1'b1}, a);
    chk(a == 1'b1, "R7", a, 1);
    for (int r = 0; r < 3; r++) begin
      rv = result_of(8'(r));
      read_byte(rb, 1'b1);
      expb = {4'hF, rv[11:8]};
      chk(rb == expb, "R7 high byte", rb, expb);
      read_byte(rb, r != 2);
      expb = rv[7:0];
      chk(rb == expb, r == 0 ? "R7 low byte" : "R8 next result", rb, expb);
    end
    chk(sda_oe == 1'b0, "R8 released", sda_oe, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sda_oe) chk(1'b0, "R8 held released", sda_oe, 0);
    end
    bus_stop();
    chk(idx == 8'd2, "R8 advance count", idx, 2);

    // R8: NACK after the first byte
    bus_start();
    write_byte({ADDR, 1'b1}, a);
    read_byte(rb, 1'b0);
    chk(rb == {4'hF, result_of(0)[11:8]}, "R8 nack first", rb, {4'hF, result_of(0)[11:8]});
    chk(sda_oe == 1'b0, "R8 nack release", sda_oe, 0);
    bus_stop();

    // R6: repeated start keeps speed mode, stop clears it
    bus_start();
    write_byte(8'h0D, a);
    chk(a == 1'b0, "R6 nack", a, 0);
    chk(hs_mode == 1'b1, "R6", hs_mode, 1);
    bus_start();
    write_byte({ADDR, 1'b0}, a);
    chk(a == 1'b1, "R6 addr in hs", a, 1);
    chk(hs_mode == 1'b1, "R6 kept", hs_mode, 1);
    write_byte(8'h23, a);
    model_write(8'h23);
    bus_stop();
    chk(hs_mode == 1'b0, "R6 cleared", hs_mode, 0);
    check_regs("R6 write");

    // R9: stop partway through a byte
    bus_start();
    write_byte({ADDR, 1'b0}, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    check_regs("R9 stop abort");

    // R9: repeated start partway through a byte
    bus_start();
    write_byte({ADDR, 1'b0}, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    bus_start();
    write_byte({ADDR, 1'b0}, a);
    chk(a == 1'b1, "R9 restart addr", a, 1);
    write_byte(8'h60, a);
    model_write(8'h60);
    bus_stop();
    check_regs("R9 restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule